// File: doc/BRIEF.md
# Two-Step Refresh Watchdog Timer

This block counts machine cycles while armed and demands a system reset when software lets it run out. A restart of the count needs two separate writes in a fixed order. First, a write to the arm bit. Then, in the very next machine cycle and no later, a write to the kick bit. A single stray write therefore cannot keep a runaway program alive. The arm bit clears itself two machine cycles after it was set, so the window for the kick is one instruction wide.

Software can start the counter with a write strobe. A start input pin can also start it. A start from the pin additionally blocks the idle and power-down modes until the next external reset. Nothing but the external reset stops a started watchdog.

On expiry the block raises a reset request for a fixed number of machine cycles and sets a sticky status flag. That flag survives the watchdog reset, so software can tell why it restarted. After the request ends, counting resumes from zero. All state advances only in clock cycles where the machine-cycle enable is high. The default sizing gives 2^16 machine cycles, about 65.5 ms at a 1 µs machine cycle.

Top module: `twostep_watchdog`

## Requirements
- R1: After external reset (rst_n low), wd_rst_req, wd_flag, wd_active, arm_state and sleep_inhibit are all 0.
- R2: A machine cycle with start_wr=1 or start_pin=1 sets wd_active from the next clock on.
- R3: Once set, wd_active stays 1 through expiries, refreshes and all write strobes; only rst_n clears it.
- R4: Without a refresh, wd_rst_req rises at the Nth machine cycle after the one that started the watchdog, with N = 2^(PRE_W+CNT_W).
- R5: An arm_wr in machine cycle T followed by kick_wr in machine cycle T+1 restarts the count from zero, so the next expiry falls N machine cycles after T+1.
- R6: A kick_wr with no arm pending, or one issued two or more machine cycles after arm_wr, has no effect on the expiry time.
- R7: arm_state goes to 1 after a machine cycle with arm_wr=1. It stays 1 for the next machine cycle and reads 0 after the second one, unless an accepted kick clears it sooner.
- R8: wd_rst_req stays 1 for exactly HOLD_MC machine cycles. Counting then resumes from zero, so the following expiry is HOLD_MC+N machine cycles after the previous one.
- R9: wd_flag becomes 1 together with wd_rst_req. It is cleared by a machine cycle with flag_clr_wr=1 or by rst_n, and an expiry in the same machine cycle as flag_clr_wr leaves it at 1.
- R10: While mc_en is 0, every write strobe and start_pin is ignored and no output changes.
- R11: sleep_inhibit becomes 1 only when the pin starts the watchdog and then stays 1 until rst_n; a software start leaves it 0.
- R12: arm_wr and kick_wr are ignored while wd_rst_req is 1: arm_state stays 0 and the count is not restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | External reset, active low, asynchronous |
| mc_en | input | 1 | Machine-cycle enable; state advances only when high |
| arm_wr | input | 1 | Strobe setting the arm bit (first refresh step) |
| kick_wr | input | 1 | Strobe setting the kick bit (second refresh step) |
| start_wr | input | 1 | Software start strobe |
| start_pin | input | 1 | External start pin, sampled on machine cycles |
| flag_clr_wr | input | 1 | Strobe clearing the status flag |
| wd_rst_req | output | 1 | Reset request to the reset network |
| wd_flag | output | 1 | Sticky flag: last reset came from the watchdog |
| wd_active | output | 1 | Watchdog started |
| arm_state | output | 1 | Readable arm bit |
| sleep_inhibit | output | 1 | Blocks idle and power-down entry (pin start) |

## Verification
The count is run to expiry several times. It runs untouched from a software start and then resumes after a reset request. It is also kept alive by correctly paired arm and kick writes, and the expiry is timed from the last accepted kick. This shows that the pairing restarts the count. Late kicks, kicks with nothing armed, and arm/kick pairs issued during the reset request must all leave the expiry exactly where an untouched count would put it. That separates a real refresh from a sequence that only looks like one. A flag clear placed exactly on an expiry cycle tests the priority between the two. Strobes with the machine-cycle enable low, and starts by pin rather than by software, show the gating and the power-mode lock.

// File: rtl/twd_pkg.sv
package twd_pkg;

   // phase of the two-step refresh: armed this cycle (fresh), one cycle later (stale)
   typedef enum logic [1:0] {
      ARM_IDLE  = 2'd0,
      ARM_FRESH = 2'd1,
      ARM_STALE = 2'd2
   } arm_phase_e;

   function automatic int unsigned hold_width(int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/twd_refresh_seq.sv
module twd_refresh_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic arm_wr,
   input  logic kick_wr,
   input  logic freeze,
   input  logic flush,
   output logic armed,
   output logic refresh_ok
);
   import twd_pkg::*;

   arm_phase_e phase_q, phase_d;

   // a kick only counts in the machine cycle right after the arm write
   assign refresh_ok = tick & kick_wr & ~freeze & (phase_q == ARM_FRESH);
   assign armed      = (phase_q != ARM_IDLE);

   always_comb begin
      phase_d = phase_q;
      if (tick) begin
         if (freeze || flush)
            phase_d = ARM_IDLE;
         else if (arm_wr)
            phase_d = ARM_FRESH;
         else if (phase_q == ARM_FRESH)
            phase_d = refresh_ok ? ARM_IDLE : ARM_STALE;
         else
            phase_d = ARM_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= ARM_IDLE;
      else        phase_q <= phase_d;
   end

endmodule

// File: rtl/twd_counter.sv
module twd_counter #(
   parameter int unsigned PRE_W = 1,
   parameter int unsigned CNT_W = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic run,
   input  logic freeze,
   input  logic clear,
   output logic wrap
);
   localparam int unsigned TOT_W = PRE_W + CNT_W;

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("twd_counter: CNT_W must lie in 2..32");
   end
   if (PRE_W > 16) begin : g_bad_pre
      $error("twd_counter: PRE_W must not exceed 16");
   end
   if (TOT_W > 40) begin : g_bad_tot
      $error("twd_counter: PRE_W+CNT_W must not exceed 40");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             pre_full;
   logic             zero_it;

   assign zero_it = freeze | clear | wrap;

   if (PRE_W == 0) begin : g_no_pre
      assign pre_full = 1'b1;
   end else begin : g_pre
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pre_q <= '0;
         else if (tick) begin
            if (zero_it)  pre_q <= '0;
            else if (run) pre_q <= pre_q + 1'b1;
         end
      end
      assign pre_full = &pre_q;
   end

   assign wrap = tick & run & ~freeze & ~clear & pre_full & (&cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (tick) begin
         if (zero_it)              cnt_q <= '0;
         else if (run && pre_full) cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/twd_supervisor.sv
module twd_supervisor #(
   parameter int unsigned HOLD_MC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic start_wr,
   input  logic start_pin,
   input  logic flag_clr,
   input  logic wrap,
   output logic active,
   output logic pin_lock,
   output logic flag,
   output logic freeze
);
   localparam int unsigned HW = twd_pkg::hold_width(HOLD_MC);
   localparam logic [HW-1:0] HOLD_INIT = HW'(HOLD_MC);

   if (HOLD_MC < 1 || HOLD_MC > 255) begin : g_bad_hold
      $error("twd_supervisor: HOLD_MC must lie in 1..255");
   end

   logic          active_q, pin_q, flag_q;
   logic [HW-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         pin_q    <= 1'b0;
         flag_q   <= 1'b0;
         hold_q   <= '0;
      end else if (tick) begin
         if (start_wr || start_pin) active_q <= 1'b1;
         if (start_pin)             pin_q    <= 1'b1;
         if (wrap)                  flag_q   <= 1'b1;
         else if (flag_clr)         flag_q   <= 1'b0;
         if (wrap)                  hold_q   <= HOLD_INIT;
         else if (hold_q != '0)     hold_q   <= hold_q - 1'b1;
      end
   end

   assign active   = active_q;
   assign pin_lock = pin_q;
   assign flag     = flag_q;
   assign freeze   = (hold_q != '0);

endmodule

// File: rtl/twostep_watchdog.sv
module twostep_watchdog #(
   parameter int unsigned PRE_W   = 1,
   parameter int unsigned CNT_W   = 15,
   parameter int unsigned HOLD_MC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mc_en,
   input  logic arm_wr,
   input  logic kick_wr,
   input  logic start_wr,
   input  logic start_pin,
   input  logic flag_clr_wr,
   output logic wd_rst_req,
   output logic wd_flag,
   output logic wd_active,
   output logic arm_state,
   output logic sleep_inhibit
);
   logic refresh_ok, wrap, freeze, active;

   twd_refresh_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (mc_en),
      .arm_wr     (arm_wr),
      .kick_wr    (kick_wr),
      .freeze     (freeze),
      .flush      (wrap),
      .armed      (arm_state),
      .refresh_ok (refresh_ok)
   );

   twd_counter #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (mc_en),
      .run    (active),
      .freeze (freeze),
      .clear  (refresh_ok),
      .wrap   (wrap)
   );

   twd_supervisor #(.HOLD_MC(HOLD_MC)) u_sup (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (mc_en),
      .start_wr (start_wr),
      .start_pin(start_pin),
      .flag_clr (flag_clr_wr),
      .wrap     (wrap),
      .active   (active),
      .pin_lock (sleep_inhibit),
      .flag     (wd_flag),
      .freeze   (freeze)
   );

   assign wd_active  = active;
   assign wd_rst_req = freeze;

endmodule

// File: rtl/twd_chk.sv
module twd_chk (
   input logic clk,
   input logic rst_n,
   input logic mc_en,
   input logic arm_wr,
   input logic wd_rst_req,
   input logic wd_flag,
   input logic wd_active,
   input logic arm_state,
   input logic sleep_inhibit
);
   p_stay_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wd_active |=> wd_active);

   p_req_needs_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wd_rst_req) |-> $past(wd_active));

   p_arm_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(arm_state) |-> $past(mc_en && arm_wr));

   p_flag_with_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wd_rst_req) |-> wd_flag);

   p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !mc_en |=> $stable({wd_rst_req, wd_flag, wd_active, arm_state, sleep_inhibit}));

   p_inhibit_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_inhibit |=> sleep_inhibit);

   p_inhibit_active_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_inhibit |-> wd_active);

   p_no_arm_in_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      wd_rst_req |-> !arm_state);

endmodule

bind twostep_watchdog twd_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mc_en        (mc_en),
   .arm_wr       (arm_wr),
   .wd_rst_req   (wd_rst_req),
   .wd_flag      (wd_flag),
   .wd_active    (wd_active),
   .arm_state    (arm_state),
   .sleep_inhibit(sleep_inhibit)
);

// File: tb/twostep_watchdog_bench.sv
module twostep_watchdog_bench;
   localparam int PRE_W = 2;
   localparam int CNT_W = 4;
   localparam int HOLD  = 3;
   localparam int N     = 1 << (PRE_W + CNT_W);

   logic clk = 1'b0;
   logic rst_n, mc_en, arm_wr, kick_wr, start_wr, start_pin, flag_clr_wr;
   logic wd_rst_req, wd_flag, wd_active, arm_state, sleep_inhibit;

   always #5 clk = ~clk;

   twostep_watchdog #(.PRE_W(PRE_W), .CNT_W(CNT_W), .HOLD_MC(HOLD)) u_twostep_watchdog (
      .clk(clk), .rst_n(rst_n), .mc_en(mc_en), .arm_wr(arm_wr), .kick_wr(kick_wr),
      .start_wr(start_wr), .start_pin(start_pin), .flag_clr_wr(flag_clr_wr),
      .wd_rst_req(wd_rst_req), .wd_flag(wd_flag), .wd_active(wd_active),
      .arm_state(arm_state), .sleep_inhibit(sleep_inhibit)
   );

   int checks = 0;
   int failures = 0;
   int tick_no = 0;
   bit reported = 0;

   // behavioural reference, advanced once per machine cycle
   int m_act, m_pin, m_arm, m_age, m_cnt, m_hold, m_flag, m_old;
   bit m_acc;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_act = 0; m_pin = 0; m_arm = 0; m_age = 0; m_cnt = 0; m_hold = 0; m_flag = 0;
      end else if (mc_en) begin
         m_acc = kick_wr && m_arm == 1 && m_age == 0 && m_hold == 0;
         m_old = m_act;
         if (start_wr || start_pin) m_act = 1;
         if (start_pin) m_pin = 1;
         if (flag_clr_wr) m_flag = 0;
         if (m_hold > 0) begin
            m_hold--; m_arm = 0; m_cnt = 0;
         end else begin
            if (arm_wr) begin m_arm = 1; m_age = 0; end
            else if (m_arm == 1) begin
               if (m_acc) m_arm = 0;
               else if (m_age == 0) m_age = 1;
               else m_arm = 0;
            end
            if (m_acc) m_cnt = 0;
            else if (m_old == 1) begin
               if (m_cnt == N - 1) begin
                  m_cnt = 0; m_hold = HOLD; m_flag = 1; m_arm = 0;
               end else m_cnt++;
            end
         end
      end
   end

   task automatic cmp(input string tag, input string nm, input logic act, input int exp);
      checks++;
      if (act !== exp[0]) begin
         failures++;
         $display("FAIL %s %s act=%0b exp=%0d at tick %0d", tag, nm, act, exp, tick_no);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         cmp("R4", "wd_rst_req", wd_rst_req, (m_hold != 0) ? 1 : 0);
         cmp("R9", "wd_flag", wd_flag, m_flag);
         cmp("R3", "wd_active", wd_active, m_act);
         cmp("R7", "arm_state", arm_state, m_arm);
         cmp("R11", "sleep_inhibit", sleep_inhibit, m_pin);
      end
   end

   task automatic chk_int(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
      end
   endtask

   task automatic step(input logic mc, input logic a, input logic k, input logic s,
                       input logic p, input logic c);
      @(negedge clk);
      mc_en = mc; arm_wr = a; kick_wr = k; start_wr = s; start_pin = p; flag_clr_wr = c;
   endtask

   task automatic tick(input logic a, input logic k, input logic s, input logic p, input logic c);
      step(1'b1, a, k, s, p, c);
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      tick_no++;
   endtask

   task automatic idle_until(input int target);
      while (tick_no < target - 1) tick(0, 0, 0, 0, 0);
   endtask

   task automatic wait_req(output int at);
      int guard = 0;
      while (wd_rst_req !== 1'b1 && guard < 1000) begin
         tick(0, 0, 0, 0, 0);
         guard++;
      end
      at = tick_no;
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired act=running exp=finished");
      report();
      $finish;
   end

   initial begin
      int t_start, rise, o1, k_last;
      rst_n = 1'b0; mc_en = 0; arm_wr = 0; kick_wr = 0; start_wr = 0; start_pin = 0; flag_clr_wr = 0;
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      chk_int("R1", "outputs", {wd_rst_req, wd_flag, wd_active, arm_state, sleep_inhibit}, 0);

      // R10 strobes without machine-cycle enable
      step(0, 1, 1, 1, 1, 1);
      step(0, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0);
      chk_int("R10", "outputs after gated strobes",
              {wd_rst_req, wd_flag, wd_active, arm_state, sleep_inhibit}, 0);

      // R2 software start; R11 no inhibit
      tick(0, 0, 1, 0, 0);
      t_start = tick_no;
      chk_int("R2", "wd_active", wd_active, 1);
      chk_int("R11", "sleep_inhibit after sw start", sleep_inhibit, 0);

      // R7 arm lifetime
      tick(1, 0, 0, 0, 0);
      chk_int("R7", "arm_state cycle 0", arm_state, 1);
      tick(0, 0, 0, 0, 0);
      chk_int("R7", "arm_state cycle 1", arm_state, 1);
      tick(0, 0, 0, 0, 0);
      chk_int("R7", "arm_state cycle 2", arm_state, 0);
      tick(0, 1, 0, 0, 0);   // R6 kick with nothing armed

      // R4 untouched expiry
      wait_req(rise);
      chk_int("R4", "ticks start to expiry", rise - t_start, N);
      chk_int("R9", "flag at expiry", wd_flag, 1);
      o1 = rise;

      // R8 hold length, R12 refresh attempt during hold
      tick(1, 0, 0, 0, 0);
      chk_int("R8", "req hold tick 1", wd_rst_req, 1);
      chk_int("R12", "arm during hold", arm_state, 0);
      tick(0, 1, 0, 0, 0);
      chk_int("R8", "req hold tick 2", wd_rst_req, 1);
      tick(0, 0, 0, 0, 0);
      chk_int("R8", "req after hold", wd_rst_req, 0);
      chk_int("R3", "active after expiry", wd_active, 1);
      wait_req(rise);
      chk_int("R12", "expiry after hold", rise - o1, HOLD + N);

      // R9 software clear
      repeat (HOLD) tick(0, 0, 0, 0, 0);
      tick(0, 0, 0, 0, 1);
      chk_int("R9", "flag after clear", wd_flag, 0);

      // R5 paired refreshes keep it alive
      for (int i = 0; i < 5; i++) begin
         repeat (40) tick(0, 0, 0, 0, 0);
         tick(1, 0, 0, 0, 0);
         tick(0, 1, 0, 0, 0);
         k_last = tick_no;
         chk_int("R5", "no req while refreshed", wd_rst_req, 0);
         chk_int("R5", "arm consumed by kick", arm_state, 0);
      end
      wait_req(rise);
      chk_int("R5", "expiry after last kick", rise - k_last, N);

      // R9 clear coinciding with an expiry
      o1 = rise;
      idle_until(o1 + 4);
      tick(0, 0, 0, 0, 1);
      chk_int("R9", "flag cleared mid run", wd_flag, 0);
      idle_until(o1 + HOLD + N);
      tick(0, 0, 0, 0, 1);
      chk_int("R9", "expiry beats clear (req)", wd_rst_req, 1);
      chk_int("R9", "expiry beats clear (flag)", wd_flag, 1);

      // R6 late kick and unarmed kick
      o1 = tick_no;
      idle_until(o1 + 9);
      tick(1, 0, 0, 0, 0);
      tick(0, 1, 0, 0, 0);
      k_last = tick_no;
      repeat (4) tick(0, 0, 0, 0, 0);
      tick(1, 0, 0, 0, 0);
      tick(0, 0, 0, 0, 0);
      tick(0, 1, 0, 0, 0);
      repeat (2) tick(0, 0, 0, 0, 0);
      tick(0, 1, 0, 0, 0);
      wait_req(rise);
      chk_int("R6", "ignored kicks keep expiry", rise - k_last, N);

      // R3 only rst_n stops; R11 pin start
      @(posedge clk); #2 rst_n = 1'b0;
      @(posedge clk); #2 rst_n = 1'b1;
      chk_int("R3", "active after rst_n", wd_active, 0);
      chk_int("R9", "flag after rst_n", wd_flag, 0);
      tick(0, 0, 0, 1, 0);
      chk_int("R2", "pin start active", wd_active, 1);
      chk_int("R11", "inhibit after pin start", sleep_inhibit, 1);
      tick(0, 0, 0, 0, 0);
      repeat (3) tick(0, 0, 0, 0, 1);
      chk_int("R11", "inhibit sticky", sleep_inhibit, 1);

      report();
      $finish;
   end

endmodule